// File: doc/BRIEF.md
# Collision-Free Bank Assignment Completer

This block takes a table that assigns each of L variables to one of P memory banks and fills in the entries that were left open. Each variable sits in two access groups. Its first group is its index modulo M, which matches the natural-order slot of a windowed decoder. Its second group is loaded together with the entry, which matches the permuted-order slot. Each group holds P variables. No two variables of one group may use the same bank, so that P parallel accesses in either order land in P different banks.

Software, or a preceding stage, writes the table through a write port. An open entry is written as bank 0, and each entry carries its second-group number. A start pulse follows. The engine first checks the filled entries for conflicts. It then handles one open entry at a time. If the entry's two groups both lack some bank, the entry takes the lowest such bank. If not, the entry takes the lowest bank missing from its first group. The engine then runs a chain of swaps that alternates between the two partitions and trades that bank for the lowest bank missing from the second group, until the conflict is gone. Every choice is made by lowest index or lowest value, so the result depends only on the loaded table. When no open entry is left, the engine raises done, and the table can be read back through a combinational read port.

Top module: `bank_map_annealer`

## Requirements
- R1: A write with `wr_en` high while the engine is idle or done stores `wr_bank` (0 = open, 1..P = bank) and `wr_grp` (second group, 0..M-1) at entry `wr_idx`. `rd_bank` shows entry `rd_idx` combinationally. The first group of entry k is k mod M.
- R2: If, at start, two non-zero entries share a bank inside one first group or inside one second group, the engine raises `err` together with `done` and leaves the table unchanged.
- R3: When `done` is high and `err` is low, no entry of the table is 0.
- R4: When `done` is high and `err` is low, no two entries with the same index modulo M hold the same bank.
- R5: When `done` is high and `err` is low, no two entries with the same second group hold the same bank.
- R6: A conflict-free table that has no open entries comes back unchanged.
- R7: An open entry whose two groups both lack a bank takes the lowest such bank, and the other entries keep their values.
- R8: An open entry whose groups share no missing bank is resolved by the alternating swap chain, and this still produces a table that meets R3 to R5.
- R9: `busy` is high from the clock edge after `start` until the edge that raises `done`, and the two are never high together. `done` stays high until the next write or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IW | Entry index to write |
| wr_bank | input | VW | Bank value to write, 0 = open |
| wr_grp | input | GW | Second-group number of the entry |
| start | input | 1 | Begin check and fill |
| rd_idx | input | IW | Entry index to read |
| rd_bank | output | VW | Bank value of entry `rd_idx` |
| busy | output | 1 | Engine is working |
| done | output | 1 | Fill finished or aborted |
| err | output | 1 | Loaded table had a conflict |

## Verification
The bench builds the block with M = 5 and P = 5, which gives 25 entries. With this size it can load the 25-entry interleaver case and its preliminary table with two open entries, one of which needs a multi-step swap chain. It also runs a fully open table over the same permutation, which forces many chains. The same size covers exact-value checks: an untouched full table, and a single open entry whose only possible bank is known. Conflicts are placed separately in a first group and in a second group to reach both branches of the error check.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_SCAN  = 3'd2,
    ST_SEC   = 3'd3,
    ST_FIR   = 3'd4,
    ST_DONE  = 3'd5
  } eng_state_t;
endpackage

// File: rtl/bank_map_usage.sv
module bank_map_usage #(
  parameter int M  = 5,
  parameter int P  = 5,
  parameter int L  = M * P,
  parameter int IW = $clog2(L),
  parameter int VW = $clog2(P + 1),
  parameter int GW = (M > 1) ? $clog2(M) : 1
) (
  input  logic [L-1:0][VW-1:0] tbl,
  input  logic [L-1:0][GW-1:0] grp2,
  output logic [M-1:0][P-1:0]  used1,
  output logic [M-1:0][P-1:0]  used2,
  output logic                 dup_any,
  output logic                 blank_any,
  output logic [IW-1:0]        blank_idx
);
  function automatic logic [P-1:0] bank_bit(input logic [VW-1:0] v);
    bank_bit = '0;
    for (int b = 0; b < P; b++)
      if (v == VW'(b + 1)) bank_bit[b] = 1'b1;
  endfunction

  always_comb begin
    used1     = '0;
    used2     = '0;
    dup_any   = 1'b0;
    blank_any = 1'b0;
    blank_idx = '0;
    for (int k = L - 1; k >= 0; k--) begin
      if (tbl[k] == '0) begin
        blank_any = 1'b1;
        blank_idx = IW'(k);
      end
    end
    for (int k = 0; k < L; k++) begin
      if (tbl[k] != '0) begin
        if ((used1[k % M] & bank_bit(tbl[k])) != '0) dup_any = 1'b1;
        used1[k % M] = used1[k % M] | bank_bit(tbl[k]);
        if (int'(grp2[k]) < M) begin
          if ((used2[grp2[k]] & bank_bit(tbl[k])) != '0) dup_any = 1'b1;
          used2[grp2[k]] = used2[grp2[k]] | bank_bit(tbl[k]);
        end
      end
    end
  end
endmodule

// File: rtl/bank_map_search.sv
module bank_map_search #(
  parameter int M  = 5,
  parameter int P  = 5,
  parameter int L  = M * P,
  parameter int IW = $clog2(L),
  parameter int VW = $clog2(P + 1),
  parameter int GW = (M > 1) ? $clog2(M) : 1
) (
  input  logic [L-1:0][VW-1:0] tbl,
  input  logic [L-1:0][GW-1:0] grp2,
  input  logic [IW-1:0]        cur,
  input  logic                 in_second,
  input  logic [VW-1:0]        target,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx
);
  logic [GW-1:0] cur_g1;
  logic [GW-1:0] cur_g2;

  always_comb begin
    cur_g1 = GW'(int'(cur) % M);
    cur_g2 = (int'(cur) < L) ? grp2[cur] : '0;
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = L - 1; k >= 0; k--) begin
      if (IW'(k) != cur && tbl[k] == target &&
          (in_second ? (grp2[k] == cur_g2) : (GW'(k % M) == cur_g1))) begin
        hit     = 1'b1;
        hit_idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/bank_map_annealer.sv
module bank_map_annealer
  import bank_map_pkg::*;
#(
  parameter int M  = 5,
  parameter int P  = 5,
  parameter int L  = M * P,
  parameter int IW = $clog2(L),
  parameter int VW = $clog2(P + 1),
  parameter int GW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [VW-1:0] wr_bank,
  input  logic [GW-1:0] wr_grp,
  input  logic          start,
  input  logic [IW-1:0] rd_idx,
  output logic [VW-1:0] rd_bank,
  output logic          busy,
  output logic          done,
  output logic          err
);
  eng_state_t          st;
  logic [L-1:0][VW-1:0] tbl;
  logic [L-1:0][GW-1:0] grp2;
  logic [IW-1:0]        cur;
  logic [VW-1:0]        val_m;
  logic [VW-1:0]        val_n;

  logic [M-1:0][P-1:0]  used1;
  logic [M-1:0][P-1:0]  used2;
  logic                 dup_any;
  logic                 blank_any;
  logic [IW-1:0]        blank_idx;
  logic                 hit;
  logic [IW-1:0]        hit_idx;

  logic [P-1:0]         free_a;
  logic [P-1:0]         free_b;
  logic [P-1:0]         free_ab;
  logic [VW-1:0]        pick_common;
  logic [VW-1:0]        pick_m;
  logic [VW-1:0]        pick_n;
  logic                 in_second;
  logic [VW-1:0]        chain_target;

  function automatic logic [VW-1:0] lowest_bank(input logic [P-1:0] msk);
    lowest_bank = '0;
    for (int b = P - 1; b >= 0; b--)
      if (msk[b]) lowest_bank = VW'(b + 1);
  endfunction

  bank_map_usage #(.M(M), .P(P), .L(L), .IW(IW), .VW(VW), .GW(GW)) u_usage (
    .tbl(tbl), .grp2(grp2), .used1(used1), .used2(used2),
    .dup_any(dup_any), .blank_any(blank_any), .blank_idx(blank_idx)
  );

  assign in_second    = (st == ST_SEC);
  assign chain_target = in_second ? val_m : val_n;

  bank_map_search #(.M(M), .P(P), .L(L), .IW(IW), .VW(VW), .GW(GW)) u_search (
    .tbl(tbl), .grp2(grp2), .cur(cur), .in_second(in_second),
    .target(chain_target), .hit(hit), .hit_idx(hit_idx)
  );

  always_comb begin
    free_a      = ~used1[int'(blank_idx) % M];
    free_b      = (int'(grp2[blank_idx]) < M) ? ~used2[grp2[blank_idx]] : '0;
    free_ab     = free_a & free_b;
    pick_common = lowest_bank(free_ab);
    pick_m      = lowest_bank(free_a);
    pick_n      = lowest_bank(free_b);
  end

  assign rd_bank = (int'(rd_idx) < L) ? tbl[rd_idx] : '0;
  assign busy    = (st == ST_CHECK) || (st == ST_SCAN) || (st == ST_SEC) || (st == ST_FIR);
  assign done    = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tbl   <= '0;
      grp2  <= '0;
      cur   <= '0;
      val_m <= '0;
      val_n <= '0;
      err   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE: begin
          if (wr_en) begin
            if (int'(wr_idx) < L) begin
              tbl[wr_idx]  <= wr_bank;
              grp2[wr_idx] <= wr_grp;
            end
            err <= 1'b0;
            st  <= ST_IDLE;
          end else if (start) begin
            err <= 1'b0;
            st  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (dup_any) begin
            err <= 1'b1;
            st  <= ST_DONE;
          end else begin
            st <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!blank_any) begin
            st <= ST_DONE;
          end else if (free_ab != '0) begin
            tbl[blank_idx] <= pick_common;
          end else begin
            tbl[blank_idx] <= pick_m;
            cur   <= blank_idx;
            val_m <= pick_m;
            val_n <= pick_n;
            st    <= ST_SEC;
          end
        end
        ST_SEC: begin
          if (hit) begin
            tbl[hit_idx] <= val_n;
            cur <= hit_idx;
            st  <= ST_FIR;
          end else begin
            st <= ST_SCAN;
          end
        end
        ST_FIR: begin
          if (hit) begin
            tbl[hit_idx] <= val_m;
            cur <= hit_idx;
            st  <= ST_SEC;
          end else begin
            st <= ST_SCAN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a finished fill leaves no open entry
  p_done_no_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> !blank_any);

  // R4 and R5: a finished fill has no bank repeated in any group
  p_done_no_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> !dup_any);

  // R2: the error flag only shows together with done
  p_err_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R9: busy and done are exclusive
  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R9: done only rises after a busy cycle
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R8: the chain only starts when the two groups share no missing bank
  p_chain_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && blank_any && free_ab == '0) |=> (st == ST_SEC));
endmodule

// File: tb/bank_map_annealer_bench.sv
module bank_map_annealer_bench;
  localparam int M  = 5;
  localparam int P  = 5;
  localparam int L  = M * P;
  localparam int IW = $clog2(L);
  localparam int VW = $clog2(P + 1);
  localparam int GW = $clog2(M);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [VW-1:0] wr_bank = '0;
  logic [GW-1:0] wr_grp = '0;
  logic          start = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [VW-1:0] rd_bank;
  logic          busy, done, err;

  int n_tests = 0;
  int n_fail  = 0;
  int perm [L];
  int grp_of [L];
  int pre [L];
  int fin [L];
  int got [L];

  always #5 clk = ~clk;

  bank_map_annealer #(.M(M), .P(P)) u_bank_map_annealer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_bank(wr_bank), .wr_grp(wr_grp), .start(start), .rd_idx(rd_idx),
    .rd_bank(rd_bank), .busy(busy), .done(done), .err(err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_all(input int vals [L]);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IW'(k); wr_bank = VW'(vals[k]); wr_grp = GW'(grp_of[k]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_all();
    for (int k = 0; k < L; k++) begin
      rd_idx = IW'(k);
      #1;
      got[k] = int'(rd_bank);
    end
  endtask

  task automatic run_fill(input string req);
    int waited;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy after start (R9)"}, int'(busy), 1);
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check({req, " done reached (R9)"}, int'(done), 1);
    check({req, " busy low at done (R9)"}, int'(busy), 0);
  endtask

  task automatic check_valid(input string req);
    int bad_blank, bad_g1, bad_g2;
    read_all();
    bad_blank = 0; bad_g1 = 0; bad_g2 = 0;
    for (int a = 0; a < L; a++) begin
      if (got[a] < 1 || got[a] > P) bad_blank++;
      for (int b = a + 1; b < L; b++) begin
        if (got[a] == got[b] && (a % M) == (b % M)) bad_g1++;
        if (got[a] == got[b] && grp_of[a] == grp_of[b]) bad_g2++;
      end
    end
    check({req, " open or out-of-range entries R3"}, bad_blank, 0);
    check({req, " first-group repeats R4"}, bad_g1, 0);
    check({req, " second-group repeats R5"}, bad_g2, 0);
  endtask

  task automatic t_reset();
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset done", int'(done), 0);
    check("R2 reset err", int'(err), 0);
  endtask

  task automatic t_load_readback();
    load_all(pre);
    read_all();
    for (int k = 0; k < L; k++) check("R1 readback of loaded entry", got[k], pre[k]);
  endtask

  task automatic t_example_chain();
    load_all(pre);
    run_fill("R8 preliminary table");
    check("R8 err low", int'(err), 0);
    check_valid("R8 preliminary table");
    @(negedge clk);
    wr_en = 1'b1; wr_idx = '0; wr_bank = VW'(got[0]); wr_grp = GW'(grp_of[0]);
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 done cleared by write", int'(done), 0);
  endtask

  task automatic t_all_open();
    int z [L];
    for (int k = 0; k < L; k++) z[k] = 0;
    load_all(z);
    run_fill("R8 all open");
    check("R8 all open err", int'(err), 0);
    check_valid("R8 all open");
  endtask

  task automatic t_full_table();
    load_all(fin);
    run_fill("R6 full table");
    check("R6 err low", int'(err), 0);
    read_all();
    for (int k = 0; k < L; k++) check("R6 entry unchanged", got[k], fin[k]);
  endtask

  task automatic t_single_open();
    int v [L];
    for (int k = 0; k < L; k++) v[k] = fin[k];
    v[13] = 0;
    load_all(v);
    run_fill("R7 single open");
    read_all();
    check("R7 open entry gets only free bank", got[13], 5);
    for (int k = 0; k < L; k++)
      if (k != 13) check("R7 other entry unchanged", got[k], fin[k]);
  endtask

  task automatic t_err_first();
    int v [L];
    for (int k = 0; k < L; k++) v[k] = 0;
    v[0] = 2; v[5] = 2;
    load_all(v);
    run_fill("R2 first-group conflict");
    check("R2 err on first-group conflict", int'(err), 1);
    read_all();
    check("R2 table kept entry 0", got[0], 2);
    check("R2 table kept open entry 1", got[1], 0);
  endtask

  task automatic t_err_second();
    int v [L];
    for (int k = 0; k < L; k++) v[k] = 0;
    v[24] = 1; v[13] = 1;
    load_all(v);
    run_fill("R2 second-group conflict");
    check("R2 err on second-group conflict", int'(err), 1);
    read_all();
    check("R2 table kept open entry 0", got[0], 0);
    check("R2 table kept entry 24", got[24], 1);
  endtask

  initial begin
    perm = '{25,10,22,3,1,14,11,5,6,2,15,13,7,16,20,24,18,8,19,17,12,21,4,23,9};
    pre  = '{3,4,3,1,0, 1,2,4,5,3, 4,1,1,2,4, 2,0,2,4,1, 5,3,5,3,5};
    fin  = '{3,4,3,1,5, 1,2,4,2,3, 4,1,1,5,4, 2,5,2,4,1, 5,3,5,3,2};
    // variable perm[p] is accessed in permuted slot p mod M
    for (int p = 0; p < L; p++) grp_of[perm[p] - 1] = p % M;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load_readback();
    t_example_chain();
    t_all_open();
    t_full_table();
    t_single_open();
    t_err_first();
    t_err_second();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule